// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Block

This block is the register file of a simple serial port, seen by a processor as sixteen 32-bit words. Bytes arrive on a byte-stream input with a valid/ready handshake and are held in a 16-entry receive queue. Software takes them out through a status word that exists at two addresses. Reading one address removes the oldest byte. Reading the other only looks at it. A write to the data-out word sends its low byte on a byte-stream output. The serial line itself, including baud timing, parity, framing and DMA, lies outside this block. The transmitter always reports itself as ready and idle.

Interrupts are level-sensitive. A raw interrupt word collects the receive-data bit and the two transmit bits. A mask word selects which raw bits drive the single interrupt line. An acknowledge word clears raw bits. After each transmit write, the first acknowledge leaves transmit bit 0 standing. Two small state machines carry the control. The receive queue moves through `RXQ_EMPTY`, `RXQ_PART` and `RXQ_FULL`:
- EMPTY to PART on an accepted byte.
- PART to FULL when the count reaches the depth.
- PART to EMPTY when the last byte is popped.
- FULL to PART on a pop.

The transmit acknowledge tracker moves from `TXF_IDLE` to `TXF_PEND` on a data-out write. It returns to `TXF_IDLE` on the next acknowledge write.

Top module: `serport_regs`

## Requirements
- R1: Reset state. The receive-control word (byte offset 0x08) reads 0x0001_0000. The receiver is disabled, rx_ready and irq are low, and the receive queue is empty.
- R2: Status word layout, at both 0x20 and 0x24. Bits 7:0 hold the oldest queued byte. Bit 16 is 1 while the queue holds data. Bit 22 (transmitter idle) and bit 24 (transmitter ready) always read 1. All other bits read 0.
- R3: A read at 0x20 removes the oldest byte when the queue is not empty. A read at 0x24 returns the same word and leaves the queue unchanged. A read at 0x20 on an empty queue has no effect.
- R4: The queue holds 16 bytes. While it is full, rx_ready is low and a byte offered on rx_valid is not stored.
- R5: Bytes are accepted only while bit 3 of the receive-control word is 1. rx_ready is high exactly when that bit is 1 and the queue is not full.
- R6: Raw interrupt bit 3 (read at 0x34) is 1 while the queue holds data and 0 once it empties.
- R7: A write to 0x1C puts its low byte on tx_data with tx_valid high for one cycle, starting the cycle after the write. The same write sets raw interrupt bits 0 and 1 and marks a transmit acknowledge as pending.
- R8: A write to 0x30 clears each raw interrupt bit written as 1, and 0x30 reads back the value applied. While a transmit acknowledge is pending, bit 0 of that write is dropped and the pending mark is cleared.
- R9: The word at 0x38 reads raw interrupt AND mask (mask at 0x2C). irq is high whenever that word is non-zero.
- R10: Every other word address reads back the last value written to it (0 after reset). Reads return data in the same cycle, and writes take effect at the next clock edge.
- R11: A pop and an accepted byte in the same cycle leave the queue count unchanged. The new byte lands behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address; bits 1:0 ignored |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Block can take a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present, one-cycle pulse |
| irq | output | 1 | Level interrupt |

## Verification
A queue pointer or count that drifts shows up within one read as a wrong byte in bits 7:0 or a wrong bit 16 on the peek address. It also shows up as rx_ready staying high at 16 entries, or as irq not falling after the last pop. If the transmit pending state is lost or left stuck, the first acknowledge after a data-out write clears bit 0 when it should not, or the second one fails to clear it. The raw word at 0x34 and the irq pin show this in the same cycle as the next read. A wrong pop-versus-peek decode changes the byte returned on the following peek.

// File: rtl/serport_pkg.sv
package serport_pkg;

    // word indices (byte offset / 4); these positions are decoded by software
    localparam int unsigned IDX_TXCTL  = 0;
    localparam int unsigned IDX_TXDMA  = 1;
    localparam int unsigned IDX_RXCTL  = 2;
    localparam int unsigned IDX_DOUT   = 7;
    localparam int unsigned IDX_STPOP  = 8;
    localparam int unsigned IDX_STPEEK = 9;
    localparam int unsigned IDX_MASK   = 11;
    localparam int unsigned IDX_ACK    = 12;
    localparam int unsigned IDX_RAW    = 13;
    localparam int unsigned IDX_MSKD   = 14;

    // status word bit positions
    localparam int unsigned ST_DAV  = 16;
    localparam int unsigned ST_IDLE = 22;
    localparam int unsigned ST_RDY  = 24;

    localparam int unsigned RX_EN_BIT  = 3;
    localparam int unsigned IRQ_RX_BIT = 3;

    localparam logic [31:0] RXCTL_RST = 32'h0001_0000;

    typedef enum logic [1:0] {
        RXQ_EMPTY = 2'd0,
        RXQ_PART  = 2'd1,
        RXQ_FULL  = 2'd2
    } rxq_state_e;

    typedef enum logic {
        TXF_IDLE = 1'b0,
        TXF_PEND = 1'b1
    } txf_state_e;

endpackage

// File: rtl/serport_rxq.sv
module serport_rxq
    import serport_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PW    = $clog2(DEPTH),
    localparam int unsigned CW    = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              empty,
    output logic              full
);

    rxq_state_e        state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [PW-1:0]     wr_q, rd_q;
    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cnt_n = cnt_q + CW'(push) - CW'(pop);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RXQ_EMPTY: if (push) state_n = (cnt_n == CW'(DEPTH)) ? RXQ_FULL : RXQ_PART;
            RXQ_PART: begin
                if (cnt_n == CW'(DEPTH))  state_n = RXQ_FULL;
                else if (cnt_n == '0)     state_n = RXQ_EMPTY;
            end
            RXQ_FULL:  if (pop && !push) state_n = RXQ_PART;
            default:   state_n = RXQ_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RXQ_EMPTY;
            cnt_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    // outputs
    always_comb begin
        head  = mem[rd_q];
        count = cnt_q;
        empty = (state_q == RXQ_EMPTY);
        full  = (state_q == RXQ_FULL);
    end

    // R4
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R4
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXQ_FULL) == (cnt_q == CW'(DEPTH)));
    // R4
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R11
    pop_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(cnt_q));

endmodule

// File: rtl/serport_irq.sv
module serport_irq
    import serport_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr,
    input  logic             ack_wr,
    input  logic             raw_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_nonempty,
    input  logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] masked,
    output logic [REG_W-1:0] ack_val,
    output logic             irq
);

    txf_state_e       state_q, state_n;
    logic [REG_W-1:0] raw_q, ack_q, ack_eff;

    // value actually applied by an acknowledge write
    always_comb begin
        ack_eff = wdata;
        if (state_q == TXF_PEND) ack_eff[0] = 1'b0;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TXF_IDLE: if (tx_wr)  state_n = TXF_PEND;
            TXF_PEND: if (ack_wr) state_n = TXF_IDLE;
            default:  state_n = TXF_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXF_IDLE;
            raw_q   <= '0;
            ack_q   <= '0;
        end else begin
            state_q <= state_n;
            if (tx_wr) begin
                raw_q <= raw_q | REG_W'(3);
            end else if (ack_wr) begin
                raw_q <= raw_q & ~ack_eff;
                ack_q <= ack_eff;
            end else if (raw_wr) begin
                raw_q <= wdata;
            end
        end
    end

    // outputs
    always_comb begin
        raw             = raw_q;
        raw[IRQ_RX_BIT] = rx_nonempty;
        masked          = raw & mask;
        ack_val         = ack_q;
        irq             = |masked;
    end

    // R7
    tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (raw[1:0] == 2'b11 && state_q == TXF_PEND));
    // R8
    ack_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && state_q == TXF_PEND) |=> raw_q[0] == $past(raw_q[0]));
    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !tx_wr) |=> state_q == TXF_IDLE);

endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IW        = ADDR_W - 2,
    localparam int unsigned NWORDS    = 1 << IW,
    localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              irq
);

    logic [IW-1:0]     idx;
    logic [31:0]       store_q [NWORDS];
    logic              push, pop, q_empty, q_full, rx_en;
    logic [DATA_W-1:0] q_head;
    logic [CW-1:0]     q_cnt;
    logic [31:0]       raw, masked, ack_val, status;
    logic              tx_wr, ack_wr, raw_wr;
    logic [DATA_W-1:0] tx_q;
    logic              txv_q;

    function automatic logic is_stored(input int unsigned i);
        return !(i == IDX_STPOP || i == IDX_STPEEK || i == IDX_ACK ||
                 i == IDX_RAW   || i == IDX_MSKD);
    endfunction

    assign idx    = bus_addr[ADDR_W-1:2];
    assign rx_en  = store_q[IDX_RXCTL][RX_EN_BIT];
    assign rx_ready = rx_en && !q_full;
    assign push   = rx_valid && rx_ready;
    assign pop    = bus_rd && (idx == IW'(IDX_STPOP)) && !q_empty;
    assign tx_wr  = bus_wr && (idx == IW'(IDX_DOUT));
    assign ack_wr = bus_wr && (idx == IW'(IDX_ACK));
    assign raw_wr = bus_wr && (idx == IW'(IDX_RAW));

    serport_rxq #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head      (q_head),
        .count     (q_cnt),
        .empty     (q_empty),
        .full      (q_full)
    );

    serport_irq #(.REG_W(32)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_wr       (tx_wr),
        .ack_wr      (ack_wr),
        .raw_wr      (raw_wr),
        .wdata       (bus_wdata),
        .rx_nonempty (!q_empty),
        .mask        (store_q[IDX_MASK]),
        .raw         (raw),
        .masked      (masked),
        .ack_val     (ack_val),
        .irq         (irq)
    );

    // plain storage words
    always_ff @(posedge clk) begin
        for (int unsigned i = 0; i < NWORDS; i++) begin
            if (!rst_n)
                store_q[i] <= (i == IDX_RXCTL) ? RXCTL_RST : '0;
            else if (bus_wr && idx == IW'(i) && is_stored(i))
                store_q[i] <= bus_wdata;
        end
    end

    // transmit byte stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txv_q <= 1'b0;
            tx_q  <= '0;
        end else begin
            txv_q <= tx_wr;
            if (tx_wr) tx_q <= bus_wdata[DATA_W-1:0];
        end
    end
    assign tx_valid = txv_q;
    assign tx_data  = tx_q;

    // status word and read mux
    always_comb begin
        status                 = '0;
        status[DATA_W-1:0]     = q_head;
        status[ST_DAV]         = !q_empty;
        status[ST_IDLE]        = 1'b1;
        status[ST_RDY]         = 1'b1;
        case (idx)
            IW'(IDX_STPOP), IW'(IDX_STPEEK): bus_rdata = status;
            IW'(IDX_RAW):                    bus_rdata = raw;
            IW'(IDX_MSKD):                   bus_rdata = masked;
            IW'(IDX_ACK):                    bus_rdata = ack_val;
            default:                         bus_rdata = store_q[idx];
        endcase
    end

    // R7
    tx_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (tx_valid && tx_data == $past(bus_wdata[DATA_W-1:0])));
    // R3
    peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == IW'(IDX_STPEEK) && !push) |=> $stable(q_cnt));
    // R5
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_q[IDX_RXCTL][RX_EN_BIT] && !pop) |=> $stable(q_cnt));

endmodule

// File: tb/test_serport_regs.sv
module test_serport_regs;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] msk;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        irq;

    int checks = 0;
    int errors = 0;
    rd_item_t   rd_q[$];
    logic [7:0] tx_exp[$];

    always #4 clk = ~clk;

    serport_regs i_serport_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    // monitor: samples 1 ns before each rising edge
    initial forever begin
        @(negedge clk);
        #3;
        if (bus_rd) begin
            rd_item_t it;
            checks++;
            if (rd_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation, actual %h expected none", bus_rdata);
            end else begin
                it = rd_q.pop_front();
                if ((bus_rdata & it.msk) !== (it.exp & it.msk)) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata & it.msk, it.exp & it.msk);
                end
            end
        end
        if (tx_valid) begin
            checks++;
            if (tx_exp.size() == 0) begin
                errors++;
                $display("FAIL R7: unexpected tx byte, actual %h expected none", tx_data);
            end else begin
                logic [7:0] e;
                e = tx_exp.pop_front();
                if (tx_data !== e) begin
                    errors++;
                    $display("FAIL R7: tx byte actual %h expected %h", tx_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
        rd_item_t it;
        @(negedge clk);
        it.exp = e; it.msk = m; it.tag = t;
        rd_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_push(input logic [5:0] a, input logic [31:0] e, input logic [7:0] b, input string t);
        rd_item_t it;
        @(negedge clk);
        it.exp = e; it.msk = '1; it.tag = t;
        rd_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1; rx_data = b; rx_valid = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pins(input logic e_irq, input logic e_rdy, input string t);
        @(negedge clk);
        #3;
        checks++;
        if (irq !== e_irq || rx_ready !== e_rdy) begin
            errors++;
            $display("FAIL %s: irq/rx_ready actual %b%b expected %b%b", t, irq, rx_ready, e_irq, e_rdy);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(6'h08, 32'h0001_0000, '1, "R1 rxctl reset");
        rd(6'h2C, 32'h0, '1, "R1 mask reset");
        pins(1'b0, 1'b0, "R1 pins after reset");
        // R2 layout on empty queue
        rd(6'h24, 32'h0140_0000, 32'hFFFF_FF00, "R2 empty status");

        // R5 disabled receiver ignores bytes
        push_byte(8'h5A);
        rd(6'h24, 32'h0140_0000, 32'hFFFF_FF00, "R5 no accept while disabled");
        wr(6'h08, 32'h0001_0008);
        pins(1'b0, 1'b1, "R5 ready once enabled");

        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        // R3 peek twice keeps the byte
        rd(6'h24, 32'h0141_0011, '1, "R3 peek first");
        rd(6'h24, 32'h0141_0011, '1, "R3 peek again");
        // R6 raw bit 3
        rd(6'h34, 32'h0000_0008, '1, "R6 raw rx bit set");
        pins(1'b0, 1'b1, "R9 masked off");
        wr(6'h2C, 32'h0000_0008);
        pins(1'b1, 1'b1, "R9 irq with mask");
        rd(6'h38, 32'h0000_0008, '1, "R9 masked word");

        // R3 pops
        rd(6'h20, 32'h0141_0011, '1, "R3 pop 11");
        rd(6'h20, 32'h0141_0022, '1, "R3 pop 22");
        // R11 pop with simultaneous arrival
        rd_push(6'h20, 32'h0141_0033, 8'h44, "R11 pop 33 with push");
        rd(6'h24, 32'h0141_0044, '1, "R11 new byte after pop");
        rd(6'h20, 32'h0141_0044, '1, "R11 pop 44");
        rd(6'h24, 32'h0140_0000, 32'hFFFF_FF00, "R11 empty after");
        rd(6'h34, 32'h0, '1, "R6 raw rx bit clear");
        pins(1'b0, 1'b1, "R9 irq falls");
        // R3 pop on empty has no effect
        rd(6'h20, 32'h0140_0000, 32'hFFFF_FF00, "R3 pop empty");
        push_byte(8'h77);
        rd(6'h20, 32'h0141_0077, '1, "R3 pop after empty pop");

        // R4 fill to depth
        for (int i = 0; i < 16; i++) push_byte(8'hA0 + 8'(i));
        pins(1'b1, 1'b0, "R4 ready low when full");
        push_byte(8'hEE);
        for (int i = 0; i < 16; i++)
            rd(6'h20, 32'h0141_00A0 + 32'(i), '1, "R4 drain order");
        rd(6'h24, 32'h0140_0000, 32'hFFFF_FF00, "R4 byte while full dropped");

        // R7 and R8 transmit and acknowledge
        wr(6'h2C, 32'h0000_0001);
        tx_exp.push_back(8'hA5);
        wr(6'h1C, 32'h0000_01A5);
        rd(6'h34, 32'h0000_0003, '1, "R7 raw tx bits");
        pins(1'b1, 1'b1, "R9 irq on tx bit");
        wr(6'h30, 32'h0000_0003);
        rd(6'h34, 32'h0000_0001, '1, "R8 first ack keeps bit 0");
        rd(6'h30, 32'h0000_0002, '1, "R8 ack readback");
        pins(1'b1, 1'b1, "R8 irq still high");
        wr(6'h30, 32'h0000_0001);
        rd(6'h34, 32'h0, '1, "R8 second ack clears");
        pins(1'b0, 1'b1, "R8 irq low");
        tx_exp.push_back(8'h01);
        wr(6'h1C, 32'h0000_0001);
        tx_exp.push_back(8'h02);
        wr(6'h1C, 32'h0000_0002);
        wr(6'h30, 32'h0000_0003);
        rd(6'h34, 32'h0000_0001, '1, "R8 one skip per pending");
        wr(6'h30, 32'h0000_0001);
        rd(6'h34, 32'h0, '1, "R8 cleared after two writes");

        // R10 plain words
        rd(6'h1C, 32'h0000_0002, '1, "R10 dout readback");
        wr(6'h00, 32'hDEAD_BEEF);
        wr(6'h10, 32'h1234_5678);
        rd(6'h00, 32'hDEAD_BEEF, '1, "R10 word 0x00");
        rd(6'h10, 32'h1234_5678, '1, "R10 word 0x10");
        rd(6'h04, 32'h0, '1, "R10 untouched word");

        repeat (3) @(posedge clk);
        checks++;
        if (tx_exp.size() != 0) begin
            errors++;
            $display("FAIL R7: missing tx bytes, actual %0d left expected 0", tx_exp.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule